// File: doc/BRIEF.md
# Multichannel Conversion Channel Sequencer

This block decides which input channel a multiplexed converter samples in the next frame. A frame is marked by a one-cycle conversion strobe, and the host supplies a command with each frame. In scan mode the block walks upward through the effective channel set and wraps back to the bottom. A channel belongs to the effective set when its enable bit is 1 and its power-down bit is 0. In fixed mode the block holds on one channel that the host named.

From reset the block is idle. It drives no active selection until a command arrives. Every command is sampled only in a strobe cycle. Its effect appears on the selection one cycle later, which is the selection used for the following frame. The per-channel rate in scan mode is the frame rate divided by the size of the effective set, because each member appears exactly once per lap. All pins are plain control and status signals. There is no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `chan_seq_top`

## Requirements
- R1: After reset, `scan_active`=0, `chan_sel`=0 and `seq_err`=0. Strobes carrying the no-op code (`cmd_op`=00) or the reserved code (11) leave the block idle.
- R2: A strobe with `cmd_op`=01 (scan restart) makes `scan_active`=1 on the next cycle. If the effective set is not empty, `chan_sel` then holds the lowest-numbered channel whose enable bit is 1 and whose power-down bit is 0.
- R3: In scan mode, each no-op strobe moves `chan_sel` to the next higher channel in the effective set.
- R4: After the highest channel of the effective set, the next no-op strobe in scan mode selects the lowest channel of the set.
- R5: A channel whose enable bit is 0 is never selected in scan mode.
- R6: A channel whose power-down bit is 1 is never selected in scan mode, even when its enable bit is 1.
- R7: A strobe with `cmd_op`=10 selects channel `cmd_chan` on the next cycle, whatever the masks hold. Later no-op strobes keep that channel.
- R8: If the effective set is empty at a strobe in scan mode, `chan_sel` keeps its value and `seq_err` becomes 1. A later strobe that finds a non-empty set, or that enters fixed mode, clears `seq_err`.
- R9: Outputs change only in the cycle after a strobe. Commands and mask changes without a strobe have no effect.
- R10: A scan-restart strobe given in fixed mode resumes scanning from the lowest effective channel. It does not continue from the fixed channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_strobe | input | 1 | One-cycle frame/conversion marker; commands are sampled here |
| cmd_op | input | 2 | 00 no-op, 01 scan restart, 10 fixed channel, 11 reserved (acts as no-op) |
| cmd_chan | input | CW | Channel index for the fixed-channel command |
| en_mask | input | N | Per-channel scan enable |
| pd_mask | input | N | Per-channel front-end power-down |
| chan_sel | output | CW | Channel used for the next conversion |
| scan_active | output | 1 | A mode has been entered (not idle) |
| seq_err | output | 1 | Scan mode found an empty effective set |

## Verification
Some properties are checked on every cycle by the assertions. The selection and flags stay frozen between strobes. The block stays idle-clean, with a zero channel and no error. Errors appear only in scan mode. A scan step with a non-empty set always lands on a channel that was effective at the strobe. A fixed channel holds under no-op frames. Other properties need the bench's scenarios with a running reference model to show them. These are the exact visiting order, wrap-around from the top channel, masks being changed between laps, error recovery, and the restart from fixed mode that goes back to the lowest channel.

// File: rtl/chan_seq_pkg.sv
package chan_seq_pkg;
  typedef enum logic [1:0] {
    OP_NOP  = 2'b00,
    OP_SCAN = 2'b01,
    OP_FIX  = 2'b10,
    OP_RSVD = 2'b11
  } seq_op_e;

  typedef enum logic [1:0] {
    MD_IDLE = 2'b00,
    MD_SCAN = 2'b01,
    MD_FIX  = 2'b10
  } seq_mode_e;
endpackage

// File: rtl/chan_seq_lowest.sv
module chan_seq_lowest #(
  parameter int N  = 8,
  parameter int CW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec,
  output logic [CW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        idx = CW'(i);
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/chan_seq_ctrl.sv
module chan_seq_ctrl
  import chan_seq_pkg::*;
#(
  parameter int N  = 8,
  parameter int CW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe,
  input  seq_op_e       op,
  input  logic [CW-1:0] fix_chan,
  input  logic [CW-1:0] low_idx,
  input  logic          low_any,
  input  logic [CW-1:0] up_idx,
  input  logic          up_any,
  output logic [CW-1:0] chan_q,
  output seq_mode_e     mode_q,
  output logic          err_q
);
  logic [CW-1:0] chan_d;
  seq_mode_e     mode_d;
  logic          err_d;
  logic          fix_ok;

  assign fix_ok = (int'(fix_chan) < N);

  always_comb begin
    chan_d = chan_q;
    mode_d = mode_q;
    err_d  = err_q;
    if (strobe) begin
      unique case (op)
        OP_SCAN: begin
          mode_d = MD_SCAN;
          err_d  = !low_any;
          if (low_any) chan_d = low_idx;
        end
        OP_FIX: begin
          if (fix_ok) begin
            mode_d = MD_FIX;
            chan_d = fix_chan;
            err_d  = 1'b0;
          end
        end
        default: begin
          if (mode_q == MD_SCAN) begin
            err_d = !low_any;
            if (up_any)       chan_d = up_idx;
            else if (low_any) chan_d = low_idx;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q <= '0;
      mode_q <= MD_IDLE;
      err_q  <= 1'b0;
    end else begin
      chan_q <= chan_d;
      mode_q <= mode_d;
      err_q  <= err_d;
    end
  end

  // R9
  hold_between_frames_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> ($stable(chan_q) && $stable(err_q)));

  // R1
  idle_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_IDLE) |-> (chan_q == '0 && !err_q));

  // R8
  err_scan_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (mode_q == MD_SCAN));

  // R7
  fix_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && mode_q == MD_FIX && op != OP_SCAN && op != OP_FIX) |=> $stable(chan_q));
endmodule

// File: rtl/chan_seq_top.sv
module chan_seq_top
  import chan_seq_pkg::*;
#(
  parameter int N  = 8,
  parameter int CW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          conv_strobe,
  input  logic [1:0]    cmd_op,
  input  logic [CW-1:0] cmd_chan,
  input  logic [N-1:0]  en_mask,
  input  logic [N-1:0]  pd_mask,
  output logic [CW-1:0] chan_sel,
  output logic          scan_active,
  output logic          seq_err
);
  logic [N-1:0]  eff;
  logic [N-1:0]  upper;
  logic [CW-1:0] low_idx, up_idx, chan_q;
  logic          low_any, up_any, err_q;
  seq_mode_e     mode_q;

  assign eff = en_mask & ~pd_mask;

  for (genvar g = 0; g < N; g++) begin : g_upper
    assign upper[g] = eff[g] && (g > int'(chan_q));
  end

  chan_seq_lowest #(.N(N), .CW(CW)) u_low (
    .vec(eff), .idx(low_idx), .any(low_any)
  );

  chan_seq_lowest #(.N(N), .CW(CW)) u_up (
    .vec(upper), .idx(up_idx), .any(up_any)
  );

  chan_seq_ctrl #(.N(N), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .strobe(conv_strobe), .op(seq_op_e'(cmd_op)),
    .fix_chan(cmd_chan), .low_idx(low_idx), .low_any(low_any),
    .up_idx(up_idx), .up_any(up_any),
    .chan_q(chan_q), .mode_q(mode_q), .err_q(err_q)
  );

  assign chan_sel    = chan_q;
  assign scan_active = (mode_q != MD_IDLE);
  assign seq_err     = err_q;

  // R5 R6
  scan_lands_effective_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_strobe && (|eff) &&
     (cmd_op == 2'b01 || (mode_q == MD_SCAN && cmd_op != 2'b10)))
    |=> ((($past(eff) >> chan_q) & {{(N-1){1'b0}}, 1'b1}) != '0));
endmodule

// File: tb/tb_chan_seq_top.sv
module tb_chan_seq_top;
  localparam int N  = 8;
  localparam int CW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          conv_strobe = 1'b0;
  logic [1:0]    cmd_op = 2'b00;
  logic [CW-1:0] cmd_chan = '0;
  logic [N-1:0]  en_mask = '0;
  logic [N-1:0]  pd_mask = '0;
  logic [CW-1:0] chan_sel;
  logic          scan_active, seq_err;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  string req = "R1";

  int m_mode = 0;
  int m_ch = 0;
  bit m_err = 1'b0;

  always #5 clk = ~clk;

  chan_seq_top #(.N(N), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .conv_strobe(conv_strobe), .cmd_op(cmd_op),
    .cmd_chan(cmd_chan), .en_mask(en_mask), .pd_mask(pd_mask),
    .chan_sel(chan_sel), .scan_active(scan_active), .seq_err(seq_err)
  );

  function automatic int lowest_eff(input logic [N-1:0] e);
    for (int i = 0; i < N; i++) if (e[i]) return i;
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_ch = 0; m_err = 1'b0;
    end else if (conv_strobe) begin
      logic [N-1:0] e;
      int lo, nx;
      e  = en_mask & ~pd_mask;
      lo = lowest_eff(e);
      if (cmd_op == 2'b01) begin
        m_mode = 1;
        if (lo < 0) m_err = 1'b1; else begin m_err = 1'b0; m_ch = lo; end
      end else if (cmd_op == 2'b10) begin
        m_mode = 2; m_ch = int'(cmd_chan); m_err = 1'b0;
      end else if (m_mode == 1) begin
        if (lo < 0) m_err = 1'b1;
        else begin
          nx = -1;
          for (int i = N - 1; i > m_ch; i--) if (e[i]) nx = i;
          m_ch = (nx < 0) ? lo : nx;
          m_err = 1'b0;
        end
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    checks++;
    if (chan_sel !== CW'(m_ch) || scan_active !== (m_mode != 0) || seq_err !== m_err) begin
      errors++;
      $display("FAIL %s: chan=%0d act=%0b err=%0b expected chan=%0d act=%0b err=%0b",
               req, chan_sel, scan_active, seq_err, m_ch, (m_mode != 0), m_err);
    end
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: cycles=%0d expected below 100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic frame(input logic [1:0] op, input int ch);
    @(negedge clk);
    conv_strobe = 1'b1; cmd_op = op; cmd_chan = CW'(ch);
    @(negedge clk);
    conv_strobe = 1'b0; cmd_op = 2'b00;
    @(negedge clk);
  endtask

  initial begin
    req = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    frame(2'b00, 0);
    frame(2'b11, 0);
    req = "R9";
    @(negedge clk); cmd_op = 2'b10; cmd_chan = 3'd4; en_mask = 8'hFF;
    repeat (3) @(negedge clk);
    cmd_op = 2'b01;
    repeat (2) @(negedge clk);
    cmd_op = 2'b00;
    req = "R2";
    en_mask = 8'b1010_0110;
    frame(2'b01, 0);
    req = "R3";
    frame(2'b00, 0);
    frame(2'b00, 0);
    req = "R5";
    frame(2'b11, 0);
    req = "R4";
    frame(2'b00, 0);
    frame(2'b00, 0);
    req = "R6";
    pd_mask = 8'b0000_0110;
    frame(2'b00, 0);
    frame(2'b00, 0);
    frame(2'b00, 0);
    frame(2'b01, 0);
    req = "R7";
    frame(2'b10, 2);
    frame(2'b00, 0);
    en_mask = 8'h00;
    frame(2'b00, 0);
    frame(2'b10, 0);
    req = "R10";
    en_mask = 8'b0101_1000;
    pd_mask = 8'h00;
    frame(2'b10, 7);
    frame(2'b01, 0);
    frame(2'b00, 0);
    req = "R8";
    en_mask = 8'b0001_0000;
    pd_mask = 8'b0001_0000;
    frame(2'b00, 0);
    frame(2'b00, 0);
    frame(2'b01, 0);
    pd_mask = 8'h00;
    frame(2'b00, 0);
    en_mask = 8'h00;
    frame(2'b00, 0);
    frame(2'b10, 5);
    req = "R4";
    en_mask = 8'b1000_0001;
    frame(2'b01, 0);
    frame(2'b00, 0);
    frame(2'b00, 0);
    frame(2'b00, 0);
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule